// File: doc/BRIEF.md
# Shared Circular Buffer Access Guard

This block decides whether a device may make its next transfer into, or out of, an external circular buffer that it shares with a host-side user. Each time a control descriptor for the buffer has been fetched, the surrounding logic presents the descriptor fields for one cycle together with an evaluate strobe. The fields are the device pointer, the user pointer, the buffer end, a user lock flag, an overwrite-enable flag, a "user has written" flag and the transfer direction (push or pull). The guard then registers a grant decision and raises status flags.

Access is refused when the user holds the buffer locked, or when the device pointer sits on a boundary. A boundary is the buffer end or the user pointer. When exactly one access remains before a boundary, access is granted and an early warning is raised. A push with overwrite enabled ignores the boundary and raises an overwrite warning instead. A pull from a buffer the user has never written raises an initial-empty warning. The five flags are sticky and are cleared by write-one-to-clear. A per-flag mask selects which flags drive a single interrupt line.

Top module: `cbuf_guard`

## Requirements
- R1: After reset, `grant_o` is 0, `status_o` is 0 and `irq_o` is 0.
- R2: Status bit positions are fixed: bit 4 lock error, bit 3 stall error, bit 2 stall early warning, bit 1 overwrite warning, bit 0 initial warning.
- R3: An evaluate with the lock flag set clears the grant and sets only the lock error bit. Lock takes priority over every other condition.
- R4: If the buffer is unlocked and the device pointer equals either the buffer end or the user pointer, the evaluate clears the grant and sets the stall error. This does not apply to a push with overwrite enabled.
- R5: If the buffer is unlocked, no boundary is hit, and the device pointer plus one (modulo 2^16) equals the buffer end or the user pointer, the evaluate sets the grant and the early warning. This does not apply to a push with overwrite enabled.
- R6: For an unlocked push with overwrite enabled, the grant is set and neither stall flag is raised. The overwrite warning is set when a boundary is hit or one access away. On a pull, overwrite-enable has no effect.
- R7: An unlocked pull whose "user has written" flag is 0 sets the initial warning. That flag never affects a push.
- R8: The grant and the status flags change only on the clock edge that samples the evaluate strobe. Between evaluates the grant holds and set flags stay set.
- R9: A clear write clears every status flag whose bit is 1 in `clr_bits_i`. If an evaluate sets the same flag in the same cycle, the flag stays set.
- R10: `irq_o` is 1 exactly when some status flag is set and its bit in `irq_mask_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | One-cycle evaluate strobe after a descriptor fetch |
| dev_ptr_i | input | 16 | Device pointer (word index) |
| usr_ptr_i | input | 16 | User pointer (word index) |
| buf_end_i | input | 16 | Buffer end (word index) |
| usr_lock_i | input | 1 | User holds the buffer locked |
| ovw_en_i | input | 1 | User allows overwrite of unread data (push only) |
| usr_written_i | input | 1 | User has written into the buffer |
| dir_push_i | input | 1 | 1 = push (device writes), 0 = pull (device reads) |
| clr_we_i | input | 1 | Status clear write enable |
| clr_bits_i | input | 5 | Write-one-to-clear pattern for the status flags |
| irq_mask_i | input | 5 | Per-flag interrupt enable |
| grant_o | output | 1 | Registered access grant |
| status_o | output | 5 | Sticky status flags |
| irq_o | output | 1 | Masked OR of the status flags |

## Verification
When the evaluate strobe is sampled at a rising edge, the grant and status results appear right after that same edge. A clear write takes effect at the same point. The interrupt follows the registered flags and the mask input without further delay. The bench drives every stimulus on the falling edge and holds the strobe for exactly one rising edge. It samples the grant, the status and the interrupt on the next falling edge. Hold and stickiness checks sample one full cycle later, after inputs have changed with no strobe applied.

// File: rtl/cbuf_guard_pkg.sv
package cbuf_guard_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int FLG_LOCK  = 4;
  localparam int FLG_STALL = 3;
  localparam int FLG_EARLY = 2;
  localparam int FLG_OVW   = 1;
  localparam int FLG_INIT  = 0;
  typedef logic [NUM_FLAGS-1:0] flags_t;
endpackage

// File: rtl/cbuf_guard_decide.sv
module cbuf_guard_decide
  import cbuf_guard_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W-1:0] dev_ptr_i,
  input  logic [PTR_W-1:0] usr_ptr_i,
  input  logic [PTR_W-1:0] buf_end_i,
  input  logic             usr_lock_i,
  input  logic             ovw_en_i,
  input  logic             usr_written_i,
  input  logic             dir_push_i,
  output logic             grant_n_o,
  output flags_t           set_n_o
);
  logic [PTR_W-1:0] next_ptr;
  logic hit_bnd, near_bnd, override;

  assign next_ptr = dev_ptr_i + PTR_W'(1);
  assign hit_bnd  = (dev_ptr_i == buf_end_i) || (dev_ptr_i == usr_ptr_i);
  assign near_bnd = (next_ptr == buf_end_i) || (next_ptr == usr_ptr_i);
  assign override = dir_push_i && ovw_en_i;

  always_comb begin
    set_n_o   = '0;
    grant_n_o = 1'b1;
    if (usr_lock_i) begin
      grant_n_o         = 1'b0;
      set_n_o[FLG_LOCK] = 1'b1;
    end else begin
      if (!dir_push_i && !usr_written_i) set_n_o[FLG_INIT] = 1'b1;
      if (override) begin
        if (hit_bnd || near_bnd) set_n_o[FLG_OVW] = 1'b1;
      end else if (hit_bnd) begin
        grant_n_o          = 1'b0;
        set_n_o[FLG_STALL] = 1'b1;
      end else if (near_bnd) begin
        set_n_o[FLG_EARLY] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbuf_guard_status.sv
module cbuf_guard_status
  import cbuf_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   eval_i,
  input  flags_t set_i,
  input  logic   clr_we_i,
  input  flags_t clr_bits_i,
  input  flags_t irq_mask_i,
  output flags_t flags_o,
  output logic   irq_o
);
  flags_t flag_q, flag_d;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      if (clr_we_i && clr_bits_i[i]) flag_d[i] = 1'b0;
      if (eval_i && set_i[i])        flag_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(clr_we_i && clr_bits_i[i])) |=> flag_q[i]); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && clr_bits_i[i] && !eval_i) |=> !flag_q[i]); // R9
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & irq_mask_i);
endmodule

// File: rtl/cbuf_guard.sv
module cbuf_guard
  import cbuf_guard_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic [PTR_W-1:0] dev_ptr_i,
  input  logic [PTR_W-1:0] usr_ptr_i,
  input  logic [PTR_W-1:0] buf_end_i,
  input  logic             usr_lock_i,
  input  logic             ovw_en_i,
  input  logic             usr_written_i,
  input  logic             dir_push_i,
  input  logic             clr_we_i,
  input  logic [4:0]       clr_bits_i,
  input  logic [4:0]       irq_mask_i,
  output logic             grant_o,
  output logic [4:0]       status_o,
  output logic             irq_o
);
  logic   grant_n, grant_d, grant_q;
  flags_t set_n, flags;

  cbuf_guard_decide #(.PTR_W(PTR_W)) decide_i (
    .dev_ptr_i     (dev_ptr_i),
    .usr_ptr_i     (usr_ptr_i),
    .buf_end_i     (buf_end_i),
    .usr_lock_i    (usr_lock_i),
    .ovw_en_i      (ovw_en_i),
    .usr_written_i (usr_written_i),
    .dir_push_i    (dir_push_i),
    .grant_n_o     (grant_n),
    .set_n_o       (set_n)
  );

  cbuf_guard_status status_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_i     (eval_i),
    .set_i      (set_n),
    .clr_we_i   (clr_we_i),
    .clr_bits_i (clr_bits_i),
    .irq_mask_i (irq_mask_i),
    .flags_o    (flags),
    .irq_o      (irq_o)
  );

  always_comb begin
    grant_d = grant_q;
    if (eval_i) grant_d = grant_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= 1'b0;
    else        grant_q <= grant_d;
  end

  assign grant_o  = grant_q;
  assign status_o = flags;

  AST_LOCK_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && usr_lock_i) |=> (!grant_o && status_o[FLG_LOCK])); // R3
  AST_STALL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !usr_lock_i && !(dir_push_i && ovw_en_i) &&
     ((dev_ptr_i == buf_end_i) || (dev_ptr_i == usr_ptr_i))) |=> !grant_o); // R4
  AST_OVERRIDE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !usr_lock_i && dir_push_i && ovw_en_i) |=> grant_o); // R6
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> $stable(grant_o)); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status_o & irq_mask_i) != 5'd0)); // R10
endmodule

// File: tb/cbuf_guard_tb_top.sv
module cbuf_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_i = 1'b0;
  logic [15:0] dev_ptr_i = '0, usr_ptr_i = '0, buf_end_i = '0;
  logic        usr_lock_i = 1'b0, ovw_en_i = 1'b0, usr_written_i = 1'b0, dir_push_i = 1'b0;
  logic        clr_we_i = 1'b0;
  logic [4:0]  clr_bits_i = '0, irq_mask_i = '0;
  logic        grant_o, irq_o;
  logic [4:0]  status_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cbuf_guard dut_i (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i),
    .dev_ptr_i(dev_ptr_i), .usr_ptr_i(usr_ptr_i), .buf_end_i(buf_end_i),
    .usr_lock_i(usr_lock_i), .ovw_en_i(ovw_en_i), .usr_written_i(usr_written_i),
    .dir_push_i(dir_push_i), .clr_we_i(clr_we_i), .clr_bits_i(clr_bits_i),
    .irq_mask_i(irq_mask_i), .grant_o(grant_o), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Bench model from the requirements. R2 bit positions: 4 lock, 3 stall, 2 early, 1 ovw, 0 init.
  function automatic logic [5:0] model(input logic [15:0] d, input logic [15:0] u,
      input logic [15:0] e, input logic lk, input logic ov, input logic wr, input logic ps);
    logic g; logic [4:0] s; logic hit, near;
    logic [15:0] dn;
    dn = 16'((32'(d) + 1) % 65536);
    hit = (d == e) || (d == u);
    near = (dn == e) || (dn == u);
    s = '0; g = 1'b1;
    if (lk) begin g = 1'b0; s = 5'b10000; end
    else begin
      if (!ps && !wr) s[0] = 1'b1;
      if (ps && ov) begin if (hit || near) s[1] = 1'b1; end
      else if (hit) begin g = 1'b0; s[3] = 1'b1; end
      else if (near) s[2] = 1'b1;
    end
    return {g, s};
  endfunction

  task automatic do_eval(input logic [15:0] d, input logic [15:0] u, input logic [15:0] e,
      input logic lk, input logic ov, input logic wr, input logic ps, input logic clr_all);
    @(negedge clk);
    dev_ptr_i = d; usr_ptr_i = u; buf_end_i = e;
    usr_lock_i = lk; ovw_en_i = ov; usr_written_i = wr; dir_push_i = ps;
    eval_i = 1'b1; clr_we_i = clr_all; clr_bits_i = clr_all ? 5'h1F : 5'h00;
    @(negedge clk);
    eval_i = 1'b0; clr_we_i = 1'b0; clr_bits_i = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] ex;
    repeat (3) @(negedge clk);
    check("R1 grant", grant_o, 0);
    check("R1 status", status_o, 0);
    irq_mask_i = 5'h1F;
    #1 check("R1 irq", irq_o, 0);
    rst_n = 1'b1;

    // Sweep: pointers 0..3, all flag combos; clear-all together with the evaluate (R9 set wins).
    for (int c = 0; c < 1024; c++) begin
      logic [15:0] d, u, e;
      d = 16'(c & 3); u = 16'((c >> 2) & 3); e = 16'((c >> 4) & 3);
      ex = model(d, u, e, c[6], c[7], c[8], c[9]);
      irq_mask_i = 5'(c * 7);
      do_eval(d, u, e, c[6], c[7], c[8], c[9], 1'b1);
      check("R3/R4/R5/R6 grant", grant_o, ex[5]);
      check("R2/R3/R4/R5/R6/R7/R9 status", status_o, ex[4:0]);
      check("R10 irq", irq_o, |(ex[4:0] & irq_mask_i));
    end

    // R5: wrap of device pointer at 0xFFFF reaching buffer end 0.
    do_eval(16'hFFFF, 16'h0100, 16'h0000, 0, 0, 1, 1, 1'b1);
    check("R5 wrap grant", grant_o, 1);
    check("R5 wrap status", status_o, 5'b00100);
    // R6: overwrite on pull has no effect: boundary still stalls.
    do_eval(16'h0040, 16'h0040, 16'h0100, 0, 1, 1, 0, 1'b1);
    check("R6 pull ovw grant", grant_o, 0);
    check("R6 pull ovw status", status_o, 5'b01000);
    // R7: unwritten on push has no effect.
    do_eval(16'h0010, 16'h0020, 16'h0100, 0, 0, 0, 1, 1'b1);
    check("R7 push unwritten status", status_o, 5'b00000);

    // R8: sticky across evaluates and hold without evaluate.
    do_eval(16'h0001, 16'h0005, 16'h0009, 1, 0, 1, 1, 1'b1);
    do_eval(16'h0001, 16'h0005, 16'h0009, 0, 0, 1, 1, 1'b0);
    check("R8 sticky lock status", status_o, 5'b10000);
    check("R8 new grant", grant_o, 1);
    @(negedge clk);
    dev_ptr_i = 16'h0005; usr_lock_i = 1'b1;
    @(negedge clk);
    check("R8 hold grant", grant_o, 1);
    check("R8 hold status", status_o, 5'b10000);

    // R9: partial clear, and clear with simultaneous set of another flag.
    do_eval(16'h0004, 16'h0005, 16'h0009, 0, 0, 0, 0, 1'b0);
    check("R9 accumulate", status_o, 5'b10101);
    @(negedge clk);
    clr_we_i = 1'b1; clr_bits_i = 5'b10001;
    @(negedge clk);
    clr_we_i = 1'b0; clr_bits_i = '0;
    check("R9 partial clear", status_o, 5'b00100);
    irq_mask_i = 5'b11011;
    #1 check("R10 masked irq", irq_o, 0);
    irq_mask_i = 5'b00100;
    #1 check("R10 enabled irq", irq_o, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule